// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block steers instruction flow for a small 8-bit processor that talks to memory over a byte-wide bus with 16-bit addresses. On a start strobe it fetches the opcode byte at the program counter. When that byte is the prefix value 0xCB it fetches the real opcode from the next address and marks the instruction as prefixed. It then shows the opcode on its outputs and raises a decode request, so that an outside decoder can answer in the same cycle with an operation kind and a condition code.

The sequencer carries out conditional absolute jumps, conditional calls and returns, and 16-bit pushes and pops through its own stack pointer. The zero and carry flags come from outside. Every memory access takes one bus cycle and moves one byte. When the new program counter is in place, a one-cycle done pulse marks the end of the instruction. An unknown operation kind raises an error and leaves both counters as they were.

Top module: `pc_stack_seq`

## Requirements
- R1: While reset is held and just after it, pc equals PC_RESET, sp equals SP_RESET, done and error are low, and neither memRead nor memWrite is asserted.
- R2: After start, the first bus cycle reads at pc. If that byte is 0xCB, a second read at pc+1 supplies the opcode and prefixed goes high. Otherwise prefixed is low. The opcode and prefixed outputs are valid while decodeReq is high, and opKind, condSel and the flags are sampled in that cycle.
- R3: condSel 0 is taken when zero is clear, 1 when zero is set, 2 when carry is clear, 3 when carry is set, and 4 always. The codes 5 to 7 are never taken.
- R4: opKind 0 is a jump. When it is taken, pc becomes the little-endian word whose low byte is at pc+1+p and whose high byte is at pc+2+p, with p equal to 1 for a prefixed instruction and 0 otherwise.
- R5: An untaken jump or call leaves pc at pc+3+p. An untaken return, a push (opKind 3) and a pop (opKind 4) leave pc at pc+1+p. All sums wrap modulo 2^16.
- R6: A push writes the high byte of pushData at sp-1 and then the low byte at sp-2, and leaves sp lower by 2, wrapping modulo 2^16.
- R7: A pop reads the low byte at sp and the high byte at sp+1, leaves sp higher by 2, and shows the word on popData. popData changes only on a pop.
- R8: A taken call (opKind 1) pushes the return address pc+3+p in the order of R6 and then loads pc with the little-endian target of R4.
- R9: A taken return (opKind 2) pops a word in the order of R7 and loads it into pc.
- R10: opKind 5 to 7 is unknown. It sets error, holds pc and sp, and writes no memory. error stays high until the next start clears it.
- R11: done is a single-cycle pulse, and pc changes only in the cycle done goes high. memRead and memWrite are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction when idle |
| opKind | input | 3 | Decoded operation, sampled while decodeReq is high |
| condSel | input | 3 | Condition code, sampled while decodeReq is high |
| flagZero | input | 1 | Zero flag |
| flagCarry | input | 1 | Carry flag |
| pushData | input | 16 | Register-pair value for push |
| memRdata | input | 8 | Read data returned in the same cycle |
| memAddr | output | 16 | Bus address |
| memRead | output | 1 | Read strobe |
| memWrite | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| opcode | output | 8 | Fetched opcode byte |
| prefixed | output | 1 | Opcode came after a prefix byte |
| decodeReq | output | 1 | Decoder answer is sampled this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| popData | output | 16 | Word from the last pop |
| done | output | 1 | Next pc is valid |
| error | output | 1 | Last instruction was unknown |
| busy | output | 1 | Instruction in progress |

## Verification
The assertions assume that the memory answers a read in the same cycle and that start is pulsed only while the block is idle. They also assume that opKind and condSel stay stable for the whole of an instruction. The bench drives start for a single cycle and holds the operation, condition, flags and pushData constant until done. Its memory model is combinational on reads and registered on writes. The random stimulus keeps code and stack in separate regions of the aliased bench memory. It also tracks the stack depth, so pops and returns never read bytes that were never pushed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PREFIX_BYTE = 8'hCB;

  localparam logic [2:0] OP_JUMP = 3'd0;
  localparam logic [2:0] OP_CALL = 3'd1;
  localparam logic [2:0] OP_RET  = 3'd2;
  localparam logic [2:0] OP_PUSH = 3'd3;
  localparam logic [2:0] OP_POP  = 3'd4;

  localparam logic [2:0] CC_NZ  = 3'd0;
  localparam logic [2:0] CC_Z   = 3'd1;
  localparam logic [2:0] CC_NC  = 3'd2;
  localparam logic [2:0] CC_C   = 3'd3;
  localparam logic [2:0] CC_ALW = 3'd4;

  typedef enum logic [2:0] {
    ADDR_PC, ADDR_PC1, ADDR_OPLO, ADDR_OPHI, ADDR_SPM1, ADDR_SP
  } addr_sel_e;

  typedef enum logic [1:0] {
    PC_HOLD, PC_FALL, PC_BUS, PC_WORD
  } pc_sel_e;

  typedef struct packed {
    addr_sel_e addrSel;
    logic      rd;
    logic      wr;
    logic      wrHigh;
    logic      pushRet;
    logic      fallLong;
    logic      latchOp;
    logic      setPfx;
    logic      clrPfx;
    logic      latchLo;
    logic      latchHi;
    logic      spDec;
    logic      spInc;
    logic      capPop;
    pc_sel_e   pcSel;
  } ctrl_t;
endpackage

// File: rtl/pcs_cond.sv
module pcs_cond
  import pcs_pkg::*;
(
  input  logic [2:0] condSel,
  input  logic       flagZero,
  input  logic       flagCarry,
  output logic       taken
);
  always_comb begin
    case (condSel)
      CC_NZ:   taken = !flagZero;
      CC_Z:    taken = flagZero;
      CC_NC:   taken = !flagCarry;
      CC_C:    taken = flagCarry;
      CC_ALW:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcs_dpath.sv
module pcs_dpath
  import pcs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PC_RESET = '0,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic [BYTE_W-1:0]  memRdata,
  input  logic [ADDR_W-1:0]  pushData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [BYTE_W-1:0]  memWdata,
  output logic [BYTE_W-1:0]  opcode,
  output logic               prefixed,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  sp,
  output logic [ADDR_W-1:0]  popData
);
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] THREE = ADDR_W'(3);

  logic [ADDR_W-1:0] pcR, spR, wordR, popR;
  logic [BYTE_W-1:0] opcodeR;
  logic              pfxR;
  logic [ADDR_W-1:0] pfxOff, opBase, fallPc, pushVal, busWord;

  always_comb begin
    pfxOff  = {{(ADDR_W-1){1'b0}}, pfxR};
    opBase  = pcR + ONE + pfxOff;
    fallPc  = pcR + (ctrl.fallLong ? THREE : ONE) + pfxOff;
    pushVal = ctrl.pushRet ? fallPc : pushData;
    busWord = {memRdata, wordR[BYTE_W-1:0]};
    case (ctrl.addrSel)
      ADDR_PC:   memAddr = pcR;
      ADDR_PC1:  memAddr = pcR + ONE;
      ADDR_OPLO: memAddr = opBase;
      ADDR_OPHI: memAddr = opBase + ONE;
      ADDR_SPM1: memAddr = spR - ONE;
      ADDR_SP:   memAddr = spR;
      default:   memAddr = pcR;
    endcase
    memWdata = ctrl.wrHigh ? pushVal[ADDR_W-1:BYTE_W] : pushVal[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcR     <= PC_RESET;
      spR     <= SP_RESET;
      wordR   <= '0;
      popR    <= '0;
      opcodeR <= '0;
      pfxR    <= 1'b0;
    end else begin
      if (ctrl.latchOp) opcodeR <= memRdata;
      if (ctrl.clrPfx)  pfxR <= 1'b0;
      if (ctrl.setPfx)  pfxR <= 1'b1;
      if (ctrl.latchLo) wordR[BYTE_W-1:0] <= memRdata;
      if (ctrl.latchHi) wordR[ADDR_W-1:BYTE_W] <= memRdata;
      if (ctrl.spDec)   spR <= spR - ONE;
      else if (ctrl.spInc) spR <= spR + ONE;
      if (ctrl.capPop)  popR <= busWord;
      case (ctrl.pcSel)
        PC_FALL: pcR <= fallPc;
        PC_BUS:  pcR <= busWord;
        PC_WORD: pcR <= wordR;
        default: pcR <= pcR;
      endcase
    end
  end

  assign opcode   = opcodeR;
  assign prefixed = pfxR;
  assign pc       = pcR;
  assign sp       = spR;
  assign popData  = popR;
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        opKind,
  input  logic              taken,
  input  logic [BYTE_W-1:0] memRdata,
  output ctrl_t             ctrl,
  output logic              decodeReq,
  output logic              done,
  output logic              error,
  output logic              busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FETCH2, S_DECODE, S_RDLO, S_RDHI,
    S_PUSHHI, S_PUSHLO, S_POPLO, S_POPHI, S_DONE
  } state_e;

  state_e state, nextState;
  logic [2:0] opR;
  logic errR, errSet;
  logic isCall;

  assign isCall = (opR == OP_CALL);

  always_comb begin
    ctrl          = '0;
    ctrl.addrSel  = ADDR_PC;
    ctrl.pcSel    = PC_HOLD;
    nextState     = state;
    errSet        = 1'b0;
    unique case (state)
      S_IDLE: if (start) nextState = S_FETCH;
      S_FETCH: begin
        ctrl.rd = 1'b1; ctrl.latchOp = 1'b1; ctrl.clrPfx = 1'b1;
        nextState = (memRdata == PREFIX_BYTE) ? S_FETCH2 : S_DECODE;
      end
      S_FETCH2: begin
        ctrl.addrSel = ADDR_PC1;
        ctrl.rd = 1'b1; ctrl.latchOp = 1'b1; ctrl.setPfx = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        case (opKind)
          OP_JUMP, OP_CALL: begin
            if (taken) nextState = S_RDLO;
            else begin
              ctrl.fallLong = 1'b1; ctrl.pcSel = PC_FALL; nextState = S_DONE;
            end
          end
          OP_RET: begin
            if (taken) nextState = S_POPLO;
            else begin
              ctrl.pcSel = PC_FALL; nextState = S_DONE;
            end
          end
          OP_PUSH: nextState = S_PUSHHI;
          OP_POP:  nextState = S_POPLO;
          default: begin
            errSet = 1'b1; nextState = S_DONE;
          end
        endcase
      end
      S_RDLO: begin
        ctrl.addrSel = ADDR_OPLO; ctrl.rd = 1'b1; ctrl.latchLo = 1'b1;
        nextState = S_RDHI;
      end
      S_RDHI: begin
        ctrl.addrSel = ADDR_OPHI; ctrl.rd = 1'b1; ctrl.latchHi = 1'b1;
        if (isCall) nextState = S_PUSHHI;
        else begin
          ctrl.pcSel = PC_BUS; nextState = S_DONE;
        end
      end
      S_PUSHHI: begin
        ctrl.addrSel = ADDR_SPM1; ctrl.wr = 1'b1; ctrl.wrHigh = 1'b1;
        ctrl.spDec = 1'b1; ctrl.pushRet = isCall; ctrl.fallLong = isCall;
        nextState = S_PUSHLO;
      end
      S_PUSHLO: begin
        ctrl.addrSel = ADDR_SPM1; ctrl.wr = 1'b1; ctrl.spDec = 1'b1;
        ctrl.pushRet = isCall; ctrl.fallLong = isCall;
        ctrl.pcSel = isCall ? PC_WORD : PC_FALL;
        nextState = S_DONE;
      end
      S_POPLO: begin
        ctrl.addrSel = ADDR_SP; ctrl.rd = 1'b1; ctrl.latchLo = 1'b1; ctrl.spInc = 1'b1;
        nextState = S_POPHI;
      end
      S_POPHI: begin
        ctrl.addrSel = ADDR_SP; ctrl.rd = 1'b1; ctrl.spInc = 1'b1;
        if (opR == OP_RET) ctrl.pcSel = PC_BUS;
        else begin
          ctrl.capPop = 1'b1; ctrl.pcSel = PC_FALL;
        end
        nextState = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      opR   <= '0;
      errR  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_DECODE) opR <= opKind;
      if (state == S_IDLE && start) errR <= 1'b0;
      else if (errSet) errR <= 1'b1;
    end
  end

  assign decodeReq = (state == S_DECODE);
  assign done      = (state == S_DONE);
  assign error     = errR;
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  opKind,
  input  logic [2:0]  condSel,
  input  logic        flagZero,
  input  logic        flagCarry,
  input  logic [15:0] pushData,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic        memRead,
  output logic        memWrite,
  output logic [7:0]  memWdata,
  output logic [7:0]  opcode,
  output logic        prefixed,
  output logic        decodeReq,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [15:0] popData,
  output logic        done,
  output logic        error,
  output logic        busy
);
  ctrl_t ctrl;
  logic  taken;

  pcs_cond u_cond (
    .condSel(condSel), .flagZero(flagZero), .flagCarry(flagCarry), .taken(taken)
  );

  pcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opKind(opKind), .taken(taken),
    .memRdata(memRdata), .ctrl(ctrl), .decodeReq(decodeReq), .done(done),
    .error(error), .busy(busy)
  );

  pcs_dpath #(.PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .memRdata(memRdata), .pushData(pushData),
    .memAddr(memAddr), .memWdata(memWdata), .opcode(opcode), .prefixed(prefixed),
    .pc(pc), .sp(sp), .popData(popData)
  );

  assign memRead  = ctrl.rd;
  assign memWrite = ctrl.wr;
endmodule

// File: rtl/pc_stack_seq_chk.sv
module pc_stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] memAddr,
  input logic        memRead,
  input logic        memWrite,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic        done,
  input logic        error,
  input logic        busy
);
  assert_no_bus_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRead && memWrite));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pc_moves_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> done);

  assert_push_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memWrite |=> (sp == $past(memAddr)));

  assert_fetch_at_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (memRead && memAddr == pc));

  assert_unknown_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> ($stable(pc) && $stable(sp)));

  assert_error_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !error);
endmodule

bind pc_stack_seq pc_stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .memAddr(memAddr), .memRead(memRead),
  .memWrite(memWrite), .pc(pc), .sp(sp), .done(done), .error(error), .busy(busy)
);

// File: tb/tb_pc_stack_seq.sv
module tb_pc_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opKind = '0;
  logic [2:0]  condSel = '0;
  logic        flagZero = 1'b0;
  logic        flagCarry = 1'b0;
  logic [15:0] pushData = '0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr;
  logic        memRead, memWrite;
  logic [7:0]  memWdata;
  logic [7:0]  opcode;
  logic        prefixed, decodeReq;
  logic [15:0] pc, sp, popData;
  logic        done, error, busy;

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;
  logic [15:0] expPc = 16'h0000;
  logic [15:0] expSp = 16'h0001;
  logic [15:0] expPop = 16'h0000;
  int depth = 0;

  logic [7:0] mem [0:1023];

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  pc_stack_seq #(.PC_RESET(16'h0000), .SP_RESET(16'h0001)) dut (.*);

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWrite) mem[memAddr[9:0]] <= memWdata;

  function automatic logic [9:0] ix(input logic [15:0] a);
    return a[9:0];
  endfunction

  function automatic logic condTrue(input logic [2:0] c, input logic z, input logic cy);
    case (c)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runStep(input logic [2:0] k, input logic [2:0] c, input logic z,
                         input logic cy, input logic pf, input logic [15:0] tgt,
                         input logic [15:0] pv);
    logic [15:0] p0, s0, newPc, newSp, ret, pfx, lenLong, lenShort;
    logic [7:0] ob, seenOp;
    logic tk, seenPf, seen, fin;
    p0 = expPc; s0 = expSp;
    pfx = {15'd0, pf};
    ob = 8'($urandom % 256);
    if (ob == 8'hCB) ob = 8'h00;
    if (pf) begin
      mem[ix(p0)] = 8'hCB; mem[ix(p0 + 16'd1)] = ob;
    end else mem[ix(p0)] = ob;
    if (k == 3'd0 || k == 3'd1) begin
      mem[ix(p0 + 16'd1 + pfx)] = tgt[7:0];
      mem[ix(p0 + 16'd2 + pfx)] = tgt[15:8];
    end
    tk = condTrue(c, z, cy);
    lenLong = p0 + 16'd3 + pfx;
    lenShort = p0 + 16'd1 + pfx;
    newPc = p0; newSp = s0; ret = 16'h0;
    case (k)
      3'd0: newPc = tk ? tgt : lenLong;
      3'd1: if (tk) begin newPc = tgt; newSp = s0 - 16'd2; ret = lenLong; depth++; end
            else newPc = lenLong;
      3'd2: if (tk) begin
              newPc = {mem[ix(s0 + 16'd1)], mem[ix(s0)]}; newSp = s0 + 16'd2; depth--;
            end else newPc = lenShort;
      3'd3: begin newPc = lenShort; newSp = s0 - 16'd2; ret = pv; depth++; end
      3'd4: begin
              newPc = lenShort; newSp = s0 + 16'd2;
              expPop = {mem[ix(s0 + 16'd1)], mem[ix(s0)]}; depth--;
            end
      default: ;
    endcase
    opKind = k; condSel = c; flagZero = z; flagCarry = cy; pushData = pv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0; fin = 1'b0; seenOp = 8'h00; seenPf = 1'b0;
    for (int i = 0; i < 40 && !fin; i++) begin
      if (decodeReq && !seen) begin seen = 1'b1; seenOp = opcode; seenPf = prefixed; end
      if (done) fin = 1'b1;
      else @(negedge clk);
    end
    check(fin, "R11 done timeout", 32'(fin), 32'd1);
    if (!fin) return;
    check(seenOp == ob, "R2 opcode", 32'(seenOp), 32'(ob));
    check(seenPf == pf, "R2 prefixed", 32'(seenPf), 32'(pf));
    check(pc == newPc, (k == 3'd0) ? "R4/R5 jump pc" : (k == 3'd1) ? "R8 call pc" :
          (k == 3'd2) ? "R9 return pc" : (k > 3'd4) ? "R10 held pc" : "R5 pc", 32'(pc), 32'(newPc));
    check(sp == newSp, (k == 3'd4 || k == 3'd2) ? "R7 sp" : "R6 sp", 32'(sp), 32'(newSp));
    check(error == (k > 3'd4), "R10 error", 32'(error), 32'(k > 3'd4));
    check(popData == expPop, "R7 popData", 32'(popData), 32'(expPop));
    if (newSp == s0 - 16'd2) begin
      check(mem[ix(s0 - 16'd1)] == ret[15:8], "R6/R8 high byte", 32'(mem[ix(s0 - 16'd1)]), 32'(ret[15:8]));
      check(mem[ix(s0 - 16'd2)] == ret[7:0], "R6/R8 low byte", 32'(mem[ix(s0 - 16'd2)]), 32'(ret[7:0]));
    end
    @(negedge clk);
    check(!done, "R11 single pulse", 32'(done), 32'd0);
    expPc = newPc; expSp = newSp;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(pc == 16'h0000, "R1 pc reset", 32'(pc), 32'h0);
    check(sp == 16'h0001, "R1 sp reset", 32'(sp), 32'h1);
    check(!memRead && !memWrite && !done && !error, "R1 idle outputs",
          {memRead, memWrite, done, error}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc == 16'h0000 && !busy, "R1 after release", 32'(pc), 32'h0);
    // directed corner cases
    runStep(3'd3, 3'd4, 0, 0, 1, 16'h0000, 16'hBEEF); // R6 prefixed push, sp wraps below 0
    runStep(3'd4, 3'd4, 0, 0, 0, 16'h0000, 16'h0000); // R7 pop wraps back up
    runStep(3'd0, 3'd1, 1, 0, 0, 16'hFFFE, 16'h0);    // R3 zero taken, R4
    runStep(3'd0, 3'd0, 1, 0, 0, 16'h1234, 16'h0);    // R5 untaken, pc wraps to 0001
    runStep(3'd1, 3'd3, 0, 1, 1, 16'h0100, 16'h0);    // R8 prefixed call
    runStep(3'd2, 3'd2, 0, 1, 1, 16'h0, 16'h0);       // R9 untaken return
    runStep(3'd2, 3'd2, 0, 0, 0, 16'h0, 16'h0);       // R9 taken return
    runStep(3'd1, 3'd2, 0, 1, 0, 16'h0200, 16'h0);    // R5 untaken call
    runStep(3'd6, 3'd4, 0, 0, 0, 16'h0, 16'h0);       // R10 unknown
    runStep(3'd0, 3'd5, 1, 1, 0, 16'h0300, 16'h0);    // R3 reserved code never taken
    runStep(3'd0, 3'd4, 0, 0, 0, 16'h0040, 16'h0);
    // constrained random
    for (int n = 0; n < 300 && cycles < 150000; n++) begin
      logic [2:0] k, c;
      logic [15:0] t;
      k = 3'($urandom % 8);
      if (k > 3'd4 && ($urandom % 4) != 0) k = 3'd0;
      c = 3'($urandom % 8);
      if (depth == 0 && (k == 3'd2 || k == 3'd4)) k = 3'd3;
      if (depth >= 60 && (k == 3'd1 || k == 3'd3)) k = 3'd4;
      t = 16'h0040 + 16'($urandom % 32'h180);
      if (expPc > 16'h01C0) begin k = 3'd0; c = 3'd4; end
      runStep(k, c, 1'($urandom), 1'($urandom), ($urandom % 4) == 0, t, 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    wait (cycles >= 180000);
    nChecks++; nErrors++;
    $display("FAIL R11 watchdog: actual 0x%0h expected 0x0", cycles);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule